// File: doc/BRIEF.md
# Notch / First-Order Low-Pass IIR Filter

This block filters one channel of signed 16-bit audio samples from an ADC. A sample comes in with a valid strobe, at most one per sample tick. The filtered result appears on the output one clock later. Two signed 16-bit coefficient inputs and a mode select set the response. In notch mode the block is a second-order section: its zeros sit on the unit circle and its poles sit behind them. In low-pass mode the same coefficient inputs give a first-order low-pass.

Host software computes the coefficients from the wanted cutoff. It uses wc = 2π·fc/fs and tan(wc/2), then writes the results to the ports in their scaled form:
- The pole-radius coefficient is negated and scaled by 2^13.
- The frequency coefficient is negated and scaled by 2^12.

A disabled filter forwards samples unchanged with the same one-cycle delay. The delay-line history is discarded in three cases: on reset, while the filter is disabled, and whenever the mode changes.

Top module: `nf_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_sample` become 0 at that edge.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, in every mode.
- R3: With `enable` low, an accepted sample appears unchanged on `out_sample` one cycle later.
- R4: Notch mode (`lp_sel` = 0). Let C0 = `coef_pole` and C1 = `coef_freq`. Then acc = (x[n] + x[n-2])·2^13 − 2·C1·x[n-1] + 2·C1·y[n-1] + C0·y[n-2]. The output y[n] is acc scaled back by 2^-13, as R6 and R7 describe.
- R5: Low-pass mode (`lp_sel` = 1). The accumulator is acc = (x[n] + x[n-1])·(4096 − C1) + 2·C1·y[n-1]. `coef_pole` has no effect in this mode.
- R6: Rounding is to nearest with halves rounded upward. The block adds 2^12 to acc and then shifts it arithmetically right by 13. For example, an acc of −4096 gives 0 and an acc of +4096 gives 1.
- R7: A rounded result above 32767 is output as 32767. A rounded result below −32768 is output as −32768. The stored y history holds the saturated value.
- R8: In any cycle where `lp_sel` differs from its value in the previous cycle, the history is cleared. A sample accepted in that same cycle sees zero history.
- R9: While `in_valid` is low, `out_sample` keeps its value and `out_valid` is 0.
- R10: While `enable` is low, the history is held at zero. The first sample after the filter is enabled again therefore sees zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 = filter, 0 = bypass |
| lp_sel | input | 1 | 0 = notch, 1 = first-order low-pass |
| coef_pole | input | 16 | Signed pole coefficient, −a0·2^13 |
| coef_freq | input | 16 | Signed frequency coefficient, −a1·2^12 |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed filtered sample |

## Verification
Two situations are hard to reach from the ports. The first is a mode switch in the middle of a stream while the history is nonzero. The bench reaches it by running notch traffic with random coefficients and then flipping `lp_sel` just before the next sample; the expected output is computed from a cleared history. The second is saturation of a recursive output that is then fed back. The bench forces it with full-scale runs of samples at both polarities, mixed with random stimulus from a fixed seed. Directed samples of ±1 with `coef_freq` = 0 land the accumulator exactly on a rounding half-step.

// File: rtl/nf_pkg.sv
package nf_pkg;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int ACC_W    = 40;
    localparam int FRAC_P   = 13;               // scaling of pole coefficient
    localparam int FRAC_F   = 12;               // scaling of frequency coefficient
    localparam int LP_UNITY = 1 << FRAC_F;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef enum logic {MODE_NOTCH = 1'b0, MODE_LOWPASS = 1'b1} mode_e;

    typedef struct packed {
        sample_t x1;
        sample_t x2;
        sample_t y1;
        sample_t y2;
    } hist_t;

    localparam acc_t RND_HALF = acc_t'(1) <<< (FRAC_P - 1);
    localparam acc_t SMAX     = acc_t'((1 << (SAMPLE_W - 1)) - 1);
    localparam acc_t SMIN     = -acc_t'(1 << (SAMPLE_W - 1));

    function automatic sample_t round_sat(acc_t a);
        acc_t r;
        r = (a + RND_HALF) >>> FRAC_P;
        if (r > SMAX)      return sample_t'(SMAX);
        else if (r < SMIN) return sample_t'(SMIN);
        else               return sample_t'(r);
    endfunction
endpackage

// File: rtl/nf_history.sv
module nf_history
    import nf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,      // discard history this cycle
    input  logic    load,       // accept a new sample/result pair
    input  sample_t x_new,
    input  sample_t y_new,
    output hist_t   h_eff       // history the current sample sees
);
    hist_t h_q;

    assign h_eff = clear ? '0 : h_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else if (load) begin
            h_q.x2 <= h_eff.x1;
            h_q.x1 <= x_new;
            h_q.y2 <= h_eff.y1;
            h_q.y1 <= y_new;
        end else if (clear) begin
            h_q <= '0;
        end
    end
endmodule

// File: rtl/nf_mac.sv
module nf_mac
    import nf_pkg::*;
(
    input  sample_t x,
    input  hist_t   h,
    input  coef_t   c_pole,
    input  coef_t   c_freq,
    input  mode_e   mode,
    output sample_t y
);
    acc_t ex, ex1, ex2, ey1, ey2, ecp, ecf;
    acc_t acc_notch, acc_lp, acc;

    assign ex  = acc_t'(x);
    assign ex1 = acc_t'(h.x1);
    assign ex2 = acc_t'(h.x2);
    assign ey1 = acc_t'(h.y1);
    assign ey2 = acc_t'(h.y2);
    assign ecp = acc_t'(c_pole);
    assign ecf = acc_t'(c_freq);

    always_comb begin
        acc_notch = ((ex + ex2) <<< FRAC_P)
                  - ((ecf * ex1) <<< 1)
                  + ((ecf * ey1) <<< 1)
                  + (ecp * ey2);
        acc_lp    = ((ex + ex1) * (acc_t'(LP_UNITY) - ecf))
                  + ((ecf * ey1) <<< 1);
        acc       = (mode == MODE_LOWPASS) ? acc_lp : acc_notch;
    end

    assign y = round_sat(acc);
endmodule

// File: rtl/nf_filter.sv
module nf_filter
    import nf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       lp_sel,
    input  logic signed [COEF_W-1:0]   coef_pole,
    input  logic signed [COEF_W-1:0]   coef_freq,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample
);
    mode_e   mode, mode_q;
    logic    mode_chg;
    hist_t   h_eff;
    sample_t y_calc;

    assign mode     = mode_e'(lp_sel);
    assign mode_chg = (mode != mode_q);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_NOTCH;
        else     mode_q <= mode;
    end

    nf_history u_hist (
        .clk   (clk),
        .rst   (rst),
        .clear (mode_chg | ~enable),
        .load  (enable & in_valid),
        .x_new (in_sample),
        .y_new (y_calc),
        .h_eff (h_eff)
    );

    nf_mac u_mac (
        .x      (in_sample),
        .h      (h_eff),
        .c_pole ((mode == MODE_LOWPASS) ? coef_t'(0) : coef_pole),
        .c_freq (coef_freq),
        .mode   (mode),
        .y      (y_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= enable ? y_calc : in_sample;
        end
    end
endmodule

// File: rtl/nf_filter_chk.sv
module nf_filter_chk
    import nf_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       enable,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_sample,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] out_sample
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_output_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    p_bypass_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !enable) |=> (out_sample == $past(in_sample)));
endmodule

bind nf_filter nf_filter_chk u_chk (.*);

// File: tb/tb_nf_filter.sv
module tb_nf_filter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic lp_sel = 1'b0;
    logic signed [15:0] coef_pole = '0;
    logic signed [15:0] coef_freq = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid;
    logic signed [15:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    longint mx1, mx2, my1, my2;

    always #10 clk = ~clk;

    nf_filter dut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model(longint x);
        longint acc, r;
        if (lp_sel)
            acc = (x + mx1) * (4096 - longint'(coef_freq)) + 2 * longint'(coef_freq) * my1;
        else
            acc = (x + mx2) * 8192 - 2 * longint'(coef_freq) * mx1
                + 2 * longint'(coef_freq) * my1 + longint'(coef_pole) * my2;
        r = (acc + 4096) >>> 13;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic clear_model();
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    task automatic send(input logic signed [15:0] x, input string req);
        longint exp;
        @(negedge clk);
        exp = enable ? model(x) : longint'(x);
        in_sample = x;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", longint'(out_valid), 1);
        check(longint'(out_sample) == exp, req, longint'(out_sample), exp);
        if (enable) begin
            mx2 = mx1; mx1 = x; my2 = my1; my1 = exp;
        end else begin
            clear_model();
        end
    endtask

    task automatic set_mode(input logic lp);
        @(negedge clk);
        if (lp != lp_sel) clear_model();
        lp_sel = lp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic signed [15:0] held;
        void'($urandom(32'd2024));
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        check(out_sample == 16'sd0, "R1", longint'(out_sample), 0);
        rst = 1'b0;

        // R3: bypass
        send(16'sd1234, "R3");
        send(-16'sd32768, "R3");
        send(16'sd32767, "R3");

        // R9: idle keeps output and drops valid
        held = out_sample;
        repeat (4) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", longint'(out_valid), 0);
            check(out_sample == held, "R9", longint'(out_sample), longint'(held));
        end

        // R6: rounding halves upward, low-pass with zero frequency coefficient
        enable = 1'b1;
        set_mode(1'b1);
        coef_freq = '0; coef_pole = 16'sd777;
        send(-16'sd1, "R6");
        send(16'sd0, "R6");
        send(16'sd1, "R6");
        send(16'sd2, "R6");

        // R7: saturation in notch mode at both polarities
        set_mode(1'b0);
        coef_pole = '0; coef_freq = '0;
        repeat (4) send(16'sd32767, "R7");
        repeat (4) send(-16'sd32768, "R7");
        coef_pole = -16'sd6000; coef_freq = 16'sd3000;
        repeat (6) send(16'sd30000, "R7");

        // R4: random notch traffic
        for (int i = 0; i < 150; i++) begin
            if (i % 50 == 0) begin
                coef_pole = 16'(-int'($urandom_range(0, 7000)));
                coef_freq = 16'(int'($urandom_range(0, 8192)) - 4096);
            end
            send(16'($urandom), "R4");
        end

        // R8: mode change mid-stream with nonzero history
        set_mode(1'b1);
        coef_freq = -16'sd2000;
        send(16'sd10000, "R8");

        // R5: random low-pass traffic, random pole coefficient must not matter
        for (int i = 0; i < 150; i++) begin
            if (i % 30 == 0) coef_freq = 16'(-int'($urandom_range(0, 4000)));
            coef_pole = 16'($urandom);
            send(16'($urandom), "R5");
        end

        // R8: back to notch, stale low-pass history discarded
        set_mode(1'b0);
        coef_pole = -16'sd4000; coef_freq = 16'sd1500;
        send(16'sd5000, "R8");
        send(16'sd5000, "R4");

        // R10: bypass then re-enable starts from zero history
        enable = 1'b0;
        send(16'sd321, "R3");
        @(negedge clk);
        enable = 1'b1;
        send(16'sd8000, "R10");
        send(-16'sd8000, "R10");

        // R2: back-to-back samples keep out_valid high
        @(negedge clk);
        in_valid = 1'b1; in_sample = 16'sd100;
        @(negedge clk);
        check(out_valid == 1'b1, "R2", longint'(out_valid), 1);
        in_sample = 16'sd200;
        @(negedge clk);
        check(out_valid == 1'b1, "R2", longint'(out_valid), 1);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", longint'(out_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule